// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

This block gathers sixteen interrupt sources and steers each of them onto one of eight interrupt lines toward a processor. Every source owns a four-bit routing field that holds a destination number and an enable flag. Each destination line has a master enable. For each line there is a readable word that shows which routed sources are pending. Firmware acknowledges edge-captured interrupts by writing ones to a clear register.

Four of the sources are external card interrupt lines, by default sources 8 to 11. Each of these lines can be set on its own to active-high or active-low and to level or edge detection. All sixteen inputs arrive from another clock domain and pass through a two-stage synchronizer before any detection. Software reaches the configuration through a simple synchronous register port. A read returns its data on the clock edge that follows the read request.

Top module: `irq_router`

## Requirements
- R1: After reset, every routing field, every output enable, the mode register and all pending state are zero. Every `irq_out` bit is low, and reading any of these registers returns zero.
- R2: Address 0 configures sources 0–7 and address 1 configures sources 8–15. Each source has a nibble at bit 4×(index mod 8): bits [2:0] give the destination line and bit 3 enables the source. Both words read back exactly as they were written.
- R3: `irq_out[n]` goes high when at least one source is pending, enabled and routed to line n, and the master enable for line n is set. That master enable is bit 16+n of address 6, and it is the only part of that word that reads back. `irq_out` is registered one cycle after the pending state it reflects.
- R4: Writing zero to both routing words disables every source, and every `irq_out` bit drops one cycle after the second write.
- R5: The status for line n is a 16-bit halfword at byte offset 2×n. It appears in word 2+n/2, in the low half for even n and the high half for odd n. Bit i is set when source i is pending, enabled and routed to n. A write to a status word has no effect.
- R6: A write to address 7 clears the edge-captured pending state of source i wherever wdata bit i is 1. Zero bits leave pending state untouched, and the register reads as zero.
- R7: Address 8 holds two bits for each external line k at bit 2k. Bit 2k set makes line k active-low, so a low pin counts as asserted.
- R8: Bit 2k+1 of address 8 chooses the trigger mode for line k: set for level, clear for edge. In edge mode the source becomes pending on the change from inactive to active and stays pending until it is cleared. In level mode the pending state follows the asserted input, so a clear has no lasting effect while the input stays active. Internal sources are level-sensitive and active-high.
- R9: Each external line keeps its own polarity and trigger mode. A mix of three active-low lines and one active-high line routes each line independently.
- R10: With `rd_en` high, `rdata` takes the addressed word at the next clock edge and then holds it while `rd_en` is low. Unmapped addresses read as zero.
- R11: From a change at `irq_in` to the matching change at `irq_out` takes four clock edges: two synchronizer stages, the pending stage and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Asynchronous interrupt sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 8 | Interrupt lines toward the processor |

## Verification
The bench first checks exact latency. If a design dropped a synchronizer stage or left the output unregistered, `irq_out` would rise a cycle early, and the fourth-edge sample catches that. It then tests edge capture against clearing: a clear with a zero in the source's bit must leave the interrupt asserted, and a level source must re-pend after a clear. A design that cleared every bit or latched level inputs would fail both checks. Lines with mixed polarity are checked next to each other, which exposes a shared or misplaced polarity bit. An active-low edge line is checked to latch on a falling pin, and a read-back of the status halfword checks where it sits in its word.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int SRC_N     = 16;
  localparam int OUT_N     = 8;
  localparam int EXT_N     = 4;
  localparam int EXT_FIRST = 8;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int FLD_W     = 4;
  localparam int OE_LSB    = 16;
  localparam int HALF_W    = 16;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_CTRL0 = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT0 = 4'd2;
  localparam logic [ADDR_W-1:0] A_OUTEN = 4'd6;
  localparam logic [ADDR_W-1:0] A_CLEAR = 4'd7;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd8;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int NUM_SRC  = 16,
  parameter int EXT_BASE = 8,
  parameter int NUM_EXT  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   src,
  input  logic [2*NUM_EXT-1:0] mode,
  input  logic [NUM_SRC-1:0]   clr,
  output logic [NUM_SRC-1:0]   pend
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i >= EXT_BASE && i < EXT_BASE + NUM_EXT) begin : g_ext
      localparam int K = i - EXT_BASE;
      logic act, prev_q, pend_q, is_level;
      assign act      = src[i] ^ mode[2*K];
      assign is_level = mode[2*K+1];
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= act;
          if (is_level) pend_q <= act;
          else          pend_q <= (pend_q & ~clr[i]) | (act & ~prev_q);
        end
      end
      assign pend[i] = pend_q;
    end else begin : g_int
      logic pend_q;
      always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= src[i];
      end
      assign pend[i] = pend_q;
    end
  end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NUM_SRC = 16,
  parameter int NUM_OUT = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         pend,
  input  logic [NUM_SRC*4-1:0]       ctrl,
  input  logic [NUM_OUT-1:0]         oe,
  output logic [NUM_OUT*NUM_SRC-1:0] status,
  output logic [NUM_OUT-1:0]         irq_out
);
  localparam int RW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  logic [NUM_OUT-1:0] out_q;

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic en;
      logic [RW-1:0] dst;
      assign en  = ctrl[4*i+3];
      assign dst = ctrl[4*i +: RW];
      assign status[n*NUM_SRC+i] = pend[i] & en & (dst == RW'(n));
    end
    always_ff @(posedge clk) begin
      if (rst) out_q[n] <= 1'b0;
      else     out_q[n] <= oe[n] & (|status[n*NUM_SRC +: NUM_SRC]);
    end
  end

  assign irq_out = out_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_OUT = 8,
  parameter int NUM_EXT = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NUM_OUT*NUM_SRC-1:0] status,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_SRC*FLD_W-1:0]   ctrl,
  output logic [NUM_OUT-1:0]         oe,
  output logic [2*NUM_EXT-1:0]       mode,
  output logic [NUM_SRC-1:0]         clr
);
  localparam int CTRL_W     = NUM_SRC * FLD_W;
  localparam int CTRL_WORDS = CTRL_W / DATA_W;
  localparam int STAT_WORDS = NUM_OUT / 2;

  logic [CTRL_W-1:0]    ctrl_q;
  logic [NUM_OUT-1:0]   oe_q;
  logic [2*NUM_EXT-1:0] mode_q;
  logic [DATA_W-1:0]    rdata_q, rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      oe_q   <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < CTRL_WORDS; w++)
        if (addr == A_CTRL0 + ADDR_W'(w)) ctrl_q[w*DATA_W +: DATA_W] <= wdata;
      if (addr == A_OUTEN) oe_q   <= wdata[OE_LSB +: NUM_OUT];
      if (addr == A_MODE)  mode_q <= wdata[2*NUM_EXT-1:0];
    end
  end

  assign clr = (wr_en && addr == A_CLEAR) ? wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < CTRL_WORDS; w++)
      if (addr == A_CTRL0 + ADDR_W'(w)) rd_mux = ctrl_q[w*DATA_W +: DATA_W];
    for (int k = 0; k < STAT_WORDS; k++)
      if (addr == A_STAT0 + ADDR_W'(k)) begin
        rd_mux[0 +: NUM_SRC]      = status[(2*k)*NUM_SRC +: NUM_SRC];
        rd_mux[HALF_W +: NUM_SRC] = status[(2*k+1)*NUM_SRC +: NUM_SRC];
      end
    if (addr == A_OUTEN) rd_mux[OE_LSB +: NUM_OUT] = oe_q;
    if (addr == A_MODE)  rd_mux[2*NUM_EXT-1:0]     = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
  assign ctrl  = ctrl_q;
  assign oe    = oe_q;
  assign mode  = mode_q;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC  = SRC_N,
  parameter int NUM_OUT  = OUT_N,
  parameter int NUM_EXT  = EXT_N,
  parameter int EXT_BASE = EXT_FIRST
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_OUT-1:0] irq_out
);
  logic [NUM_SRC-1:0]         sync_w, pend_w, clr_w;
  logic [NUM_SRC*FLD_W-1:0]   ctrl_w;
  logic [NUM_OUT-1:0]         oe_w;
  logic [2*NUM_EXT-1:0]       mode_w;
  logic [NUM_OUT*NUM_SRC-1:0] status_w;

  irq_sync #(.W(NUM_SRC)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(sync_w)
  );

  irq_src_cond #(.NUM_SRC(NUM_SRC), .EXT_BASE(EXT_BASE), .NUM_EXT(NUM_EXT)) u_cond (
    .clk(clk), .rst(rst), .src(sync_w), .mode(mode_w), .clr(clr_w), .pend(pend_w)
  );

  irq_route #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_route (
    .clk(clk), .rst(rst), .pend(pend_w), .ctrl(ctrl_w), .oe(oe_w),
    .status(status_w), .irq_out(irq_out)
  );

  irq_regs #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .NUM_EXT(NUM_EXT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status(status_w), .rdata(rdata), .ctrl(ctrl_w),
    .oe(oe_w), .mode(mode_w), .clr(clr_w)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_OUT = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  rdata,
  input logic [NUM_OUT-1:0] irq_out,
  input logic [NUM_OUT-1:0] oe,
  input logic [NUM_SRC-1:0] pend
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (irq_out == '0));

  // R3
  master_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_out & ~$past(oe)) == '0));

  // R3
  out_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (|irq_out) |-> $past(|pend));

  // R6
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CLEAR) |=> (rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq_out(irq_out), .oe(oe_w), .pend(pend_w)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  // {addr, write data, expected read-back}
  localparam int NV = 7;
  localparam logic [67:0] VEC [NV] = '{
    {4'd0, 32'h89ABCDEF, 32'h89ABCDEF},
    {4'd1, 32'h12345678, 32'h12345678},
    {4'd2, 32'hFFFFFFFF, 32'h00000000},
    {4'd6, 32'hFFFFFFFF, 32'h00FF0000},
    {4'd8, 32'hFFFFFFFF, 32'h000000FF},
    {4'd7, 32'hFFFFFFFF, 32'h00000000},
    {4'd9, 32'hFFFFFFFF, 32'h00000000}
  };
  localparam string VREQ [NV] = '{"R2", "R2", "R5", "R3", "R7", "R6", "R10"};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_out(input logic [7:0] exp, input string req);
    chk(irq_out == exp, req, {24'h0, irq_out}, {24'h0, exp});
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(1);
    // R1 reset state
    chk_out(8'h00, "R1");
    chk_rd(4'd0, 32'h0, "R1");
    chk_rd(4'd6, 32'h0, "R1");
    chk_rd(4'd8, 32'h0, "R1");

    // register vector table (R2, R3, R5, R6, R7, R10)
    for (int v = 0; v < NV; v++) begin
      logic [31:0] d;
      wr(VEC[v][67:64], VEC[v][63:32]);
      rd(VEC[v][67:64], d);
      chk(d == VEC[v][31:0], VREQ[v], d, VEC[v][31:0]);
    end
    wr(4'd0, 32'h0); wr(4'd1, 32'h0); wr(4'd8, 32'h0); wr(4'd6, 32'h0);
    wait_n(5);

    // R3, R11: internal source 3 routed to line 5, exact latency
    wr(4'd0, 32'h0000D000);
    wr(4'd6, 32'h00200000);
    @(negedge clk); irq_in[3] = 1'b1;
    wait_n(3);
    chk_out(8'h00, "R11");
    wait_n(1);
    chk_out(8'h20, "R11");
    // R5: line 5 -> word 4 high half, bit 3
    chk_rd(4'd4, 32'h00080000, "R5");
    // R3: master enable off
    wr(4'd6, 32'h0);
    wait_n(1);
    chk_out(8'h00, "R3");
    wr(4'd6, 32'h00FF0000);
    wait_n(2);
    chk_out(8'h20, "R3");
    // R4: zero both routing words
    wr(4'd0, 32'h0); wr(4'd1, 32'h0);
    wait_n(1);
    chk_out(8'h00, "R4");
    irq_in[3] = 1'b0;
    wait_n(5);

    // R8, R6: edge line 0 (source 8) active-high to line 1
    wr(4'd1, 32'h00000009);
    @(negedge clk); irq_in[8] = 1'b1;
    wait_n(2); irq_in[8] = 1'b0;
    wait_n(6);
    chk_out(8'h02, "R8");
    wr(4'd7, 32'h0000FEFF);
    wait_n(2);
    chk_out(8'h02, "R6");
    wr(4'd7, 32'h00000100);
    wait_n(2);
    chk_out(8'h00, "R6");
    chk_rd(4'd2, 32'h0, "R6");

    // R8: level line 1 (source 9) to line 2, re-pends after clear
    wr(4'd8, 32'h00000008);
    wr(4'd1, 32'h000000A0);
    @(negedge clk); irq_in[9] = 1'b1;
    wait_n(5);
    chk_out(8'h04, "R8");
    wr(4'd7, 32'h00000200);
    wait_n(3);
    chk_out(8'h04, "R8");
    irq_in[9] = 1'b0;
    wait_n(5);
    chk_out(8'h00, "R8");

    // R9: lines 0,1,3 level active-low, line 2 level active-high
    irq_in[11:8] = 4'b1011;
    wr(4'd8, 32'h000000EF);
    wr(4'd1, 32'h0000BA98);
    wait_n(5);
    chk_out(8'h00, "R9");
    irq_in[9] = 1'b0;
    wait_n(5);
    chk_out(8'h02, "R9");
    irq_in[10] = 1'b1;
    wait_n(5);
    chk_out(8'h06, "R9");
    irq_in[9] = 1'b1; irq_in[10] = 1'b0;
    wait_n(5);
    chk_out(8'h00, "R9");

    // R7: line 0 edge active-low, latches on falling pin
    wr(4'd8, 32'h000000ED);
    wait_n(3);
    irq_in[8] = 1'b0;
    wait_n(3);
    irq_in[8] = 1'b1;
    wait_n(5);
    chk_out(8'h01, "R7");
    chk_rd(4'd2, 32'h00000100, "R7");

    // R1: reset mid-run clears pending and configuration
    @(negedge clk); rst = 1'b1;
    wait_n(2); rst = 1'b0;
    wait_n(1);
    chk_out(8'h00, "R1");
    chk_rd(4'd1, 32'h0, "R1");
    chk_rd(4'd8, 32'h0, "R1");

    done = 1'b1;
    summary();
  end
endmodule